// File: doc/BRIEF.md
# Counter-to-Floating-Point Compressor

This block squeezes a wide unsigned timer reading into a short word built from a small exponent and a fixed-width mantissa. Small readings pass through exactly. Large readings keep their top bits and lose the bits below them. The format keeps the leading one explicitly in the mantissa and has no hidden bit. The exponent field is the number of places the input was shifted right, so a reader gets the approximate value back as `mantissa << exponent`.

A level strobe marks when a new reading is wanted. The block watches the strobe for a low-to-high change, sampled on the clock. In the clock cycle where it sees that change, it converts the input present in that cycle and holds the result on its output until the next rising strobe or a reset. A priority encoder finds the highest set bit, a small function turns that position into a shift count, and a multiplexer-style aligner selects the mantissa window.

Top module: `cfp_compress`

## Requirements
- R1: A synchronous active-high `rst` clears `word_out` to 16'h0000 at the next clock edge.
- R2: `word_out[15:12]` carries the exponent and `word_out[11:0]` carries the mantissa. For example, the input 27'h0123456 encodes as 16'h991A.
- R3: When the highest set bit of the input is at bit 11 or below, the exponent is 0 and the mantissa equals the input.
- R4: When the highest set bit is at position p, with p from 12 to 26, the exponent is p-11. For example, 4096 encodes as 16'h1800 and 2^26 encodes as 16'hF800.
- R5: The mantissa is the input shifted right by the exponent and cut to 12 bits. The shifted-out bits are dropped with no rounding, so mantissa bit 11 is 1 whenever the exponent is non-zero.
- R6: An input of zero encodes as 16'h0000.
- R7: `word_out` changes only in a clock cycle where `calc` is 1 and was 0 in the previous cycle (or was held in reset). Holding `calc` high, or changing `value_in` with no rising strobe, leaves `word_out` unchanged.
- R8: The decoded value `mantissa << exponent` never exceeds the captured input, and it is less than the input by under 2^exponent.
- R9: The largest input, 2^27-1, encodes as 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| calc | input | 1 | Conversion strobe; a rising level seen on the clock captures a new result |
| value_in | input | 27 | Unsigned timer reading to compress |
| word_out | output | 16 | Registered result: exponent in [15:12], mantissa in [11:0] |

## Verification
The bench drives one value with its highest set bit in each of the 27 positions, with a noise pattern below the leading one. This separates an exponent off by one from a mantissa window taken at the wrong offset. Zero, 4095, 4096 and the all-ones input mark the edges between the pass-through range and the shifted range. Runs where `calc` stays high or low while the input moves show whether the capture follows the strobe's rising edge rather than its level. A long pseudo-random stretch with irregular strobe spacing is compared every cycle against a behavioural encoder, and the truncation bound is checked on each captured word.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    // Default geometry of the compressed timer word
    localparam int CFP_IN_W   = 27;
    localparam int CFP_MANT_W = 12;
    localparam int CFP_EXP_W  = 4;

    // Map a leading-one position onto a right-shift count.
    // Positions inside the mantissa field need no shift.
    function automatic int lead_to_shift(input int lead, input int mant_w);
        if (lead >= mant_w)
            return lead - (mant_w - 1);
        else
            return 0;
    endfunction

endpackage

// File: rtl/cfp_strobe_edge.sv
module cfp_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= 1'b0;
        else
            level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/cfp_lead_detect.sv
module cfp_lead_detect #(
    parameter int IN_W = cfp_pkg::CFP_IN_W,
    localparam int POS_W = $clog2(IN_W)
) (
    input  logic [IN_W-1:0]  value_i,
    output logic [POS_W-1:0] pos_o
);

    // Scan upward; the highest set bit wins. A zero input yields position 0.
    always_comb begin
        pos_o = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (value_i[i])
                pos_o = POS_W'(i);
        end
    end

endmodule

// File: rtl/cfp_align.sv
module cfp_align #(
    parameter int IN_W   = cfp_pkg::CFP_IN_W,
    parameter int MANT_W = cfp_pkg::CFP_MANT_W,
    parameter int EXP_W  = cfp_pkg::CFP_EXP_W,
    localparam int MAX_SH = IN_W - MANT_W
) (
    input  logic [IN_W-1:0]   value_i,
    input  logic [EXP_W-1:0]  shift_i,
    output logic [MANT_W-1:0] mant_o
);

    // One candidate window per legal shift count
    logic [MANT_W-1:0] window [0:MAX_SH];

    for (genvar s = 0; s <= MAX_SH; s++) begin : g_win
        assign window[s] = value_i[s+MANT_W-1 : s];
    end

    // AND-OR select driven by a decoded shift count
    always_comb begin
        mant_o = '0;
        for (int s = 0; s <= MAX_SH; s++) begin
            if (shift_i == EXP_W'(s))
                mant_o = mant_o | window[s];
        end
    end

endmodule

// File: rtl/cfp_compress.sv
module cfp_compress #(
    parameter int IN_W   = cfp_pkg::CFP_IN_W,
    parameter int MANT_W = cfp_pkg::CFP_MANT_W,
    parameter int EXP_W  = cfp_pkg::CFP_EXP_W,
    localparam int WORD_W = EXP_W + MANT_W,
    localparam int POS_W  = $clog2(IN_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              calc,
    input  logic [IN_W-1:0]   value_in,
    output logic [WORD_W-1:0] word_out
);

    logic              capture;
    logic [POS_W-1:0]  lead_pos;
    logic [EXP_W-1:0]  shift_amt;
    logic [MANT_W-1:0] mant;
    logic [WORD_W-1:0] word_q;

    cfp_strobe_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (calc),
        .rise_o  (capture)
    );

    cfp_lead_detect #(
        .IN_W (IN_W)
    ) u_lead (
        .value_i (value_in),
        .pos_o   (lead_pos)
    );

    always_comb begin
        shift_amt = EXP_W'(cfp_pkg::lead_to_shift(int'(lead_pos), MANT_W));
    end

    cfp_align #(
        .IN_W   (IN_W),
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W)
    ) u_align (
        .value_i (value_in),
        .shift_i (shift_amt),
        .mant_o  (mant)
    );

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (capture)
            word_q <= {shift_amt, mant};
    end

    assign word_out = word_q;

endmodule

// File: rtl/cfp_compress_chk.sv
module cfp_compress_chk #(
    parameter int IN_W   = cfp_pkg::CFP_IN_W,
    parameter int MANT_W = cfp_pkg::CFP_MANT_W,
    parameter int EXP_W  = cfp_pkg::CFP_EXP_W,
    localparam int WORD_W = EXP_W + MANT_W
) (
    input logic              clk,
    input logic              rst,
    input logic              calc,
    input logic [IN_W-1:0]   value_in,
    input logic [WORD_W-1:0] word_out
);

    logic        calc_seen;
    logic        strobe;
    logic [63:0] decoded;

    always_ff @(posedge clk) begin
        if (rst)
            calc_seen <= 1'b0;
        else
            calc_seen <= calc;
    end

    assign strobe  = calc & ~calc_seen;
    assign decoded = 64'(word_out[MANT_W-1:0]) << word_out[WORD_W-1:MANT_W];

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (word_out == '0));

    // R7
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(word_out));

    // R3
    small_passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && value_in[IN_W-1:MANT_W] == '0) |=>
        (word_out[WORD_W-1:MANT_W] == '0 &&
         word_out[MANT_W-1:0] == $past(value_in[MANT_W-1:0])));

    // R5
    normalised_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && value_in[IN_W-1:MANT_W] != '0) |=>
        (word_out[MANT_W-1] && word_out[WORD_W-1:MANT_W] != '0));

    // R6
    zero_word_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && value_in == '0) |=> (word_out == '0));

    // R8
    trunc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=>
        (decoded <= 64'($past(value_in)) &&
         (64'($past(value_in)) - decoded) < (64'd1 << word_out[WORD_W-1:MANT_W])));

endmodule

bind cfp_compress cfp_compress_chk #(
    .IN_W   (IN_W),
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W)
) u_cfp_chk (
    .clk      (clk),
    .rst      (rst),
    .calc     (calc),
    .value_in (value_in),
    .word_out (word_out)
);

// File: tb/test_cfp_compress.sv
module test_cfp_compress;

    logic        clk = 1'b0;
    logic        rst;
    logic        calc;
    logic [26:0] value_in;
    logic [15:0] word_out;

    int vectors = 0;
    int misses  = 0;

    logic [15:0] exp_word;
    logic        exp_prev;
    logic [31:0] lfsr;

    always #4 clk = ~clk;

    cfp_compress i_cfp_compress (
        .clk      (clk),
        .rst      (rst),
        .calc     (calc),
        .value_in (value_in),
        .word_out (word_out)
    );

    // Behavioural encoder written from the requirements
    function automatic logic [15:0] ref_encode(input logic [26:0] v);
        int lead = -1;
        int e;
        logic [26:0] sh;
        for (int i = 0; i < 27; i++)
            if (v[i]) lead = i;
        e  = (lead >= 12) ? lead - 11 : 0;
        sh = v >> e;
        return {4'(e), sh[11:0]};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        vectors++;
        if (act !== expv) begin
            misses++;
            $display("FAIL %s: word_out actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Drive one cycle, advance the model, compare after the edge
    task automatic step(input logic r, input logic c, input logic [26:0] v, input string tag);
        rst      = r;
        calc     = c;
        value_in = v;
        if (r) begin
            exp_word = '0;
            exp_prev = 1'b0;
        end else begin
            if (c && !exp_prev) exp_word = ref_encode(v);
            exp_prev = c;
        end
        @(negedge clk);
        check(tag, word_out, exp_word);
    endtask

    task automatic pulse(input logic [26:0] v, input string tag);
        step(1'b0, 1'b1, v, tag);
        step(1'b0, 1'b0, v, tag);
    endtask

    task automatic bound_check(input logic [26:0] v);
        longint dec;
        longint diff;
        dec  = longint'(word_out[11:0]) << word_out[15:12];
        diff = longint'(v) - dec;
        vectors++;
        if (dec > longint'(v) || diff >= (longint'(1) << word_out[15:12])) begin
            misses++;
            $display("FAIL R8: decoded actual=%0d expected within 2^%0d below %0d",
                     dec, word_out[15:12], v);
        end
    endtask

    initial begin
        #(8 * 200000);
        misses++;
        $display("FAIL R7 watchdog: actual=still running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst = 1'b1; calc = 1'b0; value_in = '0;
        exp_word = '0; exp_prev = 1'b0;
        lfsr = 32'hACE1_2468;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 27'h5A5A5A5, "R1");

        // R6: zero input
        pulse(27'h0, "R6");
        // R3: pass-through range
        pulse(27'h1, "R3");
        pulse(27'h0A5, "R3");
        pulse(27'd4095, "R3");
        // R4: first shifted value
        pulse(27'd4096, "R4");
        check("R4", word_out, 16'h1800);
        // R2: field placement for a fixed example
        pulse(27'h0123456, "R2");
        check("R2", word_out, 16'h991A);
        // R9: full scale
        pulse(27'h7FFFFFF, "R9");
        check("R9", word_out, 16'hFFFF);

        // R4 / R5: every leading-one position with noise below it
        for (int p = 0; p < 27; p++) begin
            logic [26:0] v;
            v = (27'd1 << p) | ((27'h2AAAAAA & ((27'd1 << p) - 27'd1)));
            pulse(v, p >= 12 ? "R4" : "R3");
            step(1'b0, 1'b0, v, "R5");
            bound_check(v);
        end
        step(1'b0, 1'b0, 27'h4000000, "R4");
        pulse(27'h4000000, "R4");
        check("R4", word_out, 16'hF800);

        // R7: strobe held high while the input moves
        step(1'b0, 1'b1, 27'h0000123, "R7");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 27'h0100000 + 27'(i), "R7");
        check("R7", word_out, 16'h0123);
        // R7: strobe low while the input moves
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 27'h7000000 - 27'(i), "R7");
        check("R7", word_out, 16'h0123);

        // R5 / R8: pseudo-random values and strobe spacing
        for (int n = 0; n < 400; n++) begin
            logic [26:0] v;
            int sh;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            sh   = int'(lfsr[4:0]) % 27;
            v    = 27'({lfsr, lfsr[15:0]} >> sh);
            step(1'b0, lfsr[7] | lfsr[9], v, "R5");
            if (lfsr[7] | lfsr[9]) begin
                if (exp_word == ref_encode(v) && word_out == exp_word) bound_check(v);
            end
        end

        // R1: reset in the middle of operation
        pulse(27'h7FFFFFF, "R9");
        step(1'b1, 1'b1, 27'h7FFFFFF, "R1");
        check("R1", word_out, 16'h0000);
        // R7: strobe already high when reset releases counts as a rise
        step(1'b0, 1'b1, 27'd4096, "R7");
        step(1'b0, 1'b1, 27'd5, "R7");
        check("R7", word_out, 16'h1800);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule